// File: doc/BRIEF.md
# Converter Reset and Power-Down Sequencer

This block decides when a sampled-data converter may leave reset and when its digital output may carry data. It watches an active-low external reset request and two supply-good flags, all brought into the system clock domain by a synchronizer. While any of them reports a problem, the converter core is held in reset and its output is gated to zero. Once all conditions are good, the block waits a few system clocks and then counts a fixed number of sample periods. Only after that count does it open the output gate and raise a data-valid flag.

The sample-period tick comes from one of two places. In master mode it is derived internally by dividing the system clock by a selectable ratio. In slave mode it is an externally supplied one-cycle strobe taken from the frame (LR) clock. The same tick also times power-down entry. When the external reset request stays low for longer than a large number of sample periods, a power-down flag is raised. The flag drops as soon as the request returns high, and the full release sequence then runs again.

Top module: `conv_rst_seq`

## Requirements
- R1: `conv_rst` is high whenever `ext_rst_n` is low, `vlo_ok` is low or `vhi_ok` is low. It follows them after a two-flop synchronizer, so it is asserted no later than the third rising clock edge after the cause appears.
- R2: After all three conditions become true, `conv_rst` falls on the sixth rising edge after `ext_rst_n` rises: two edges are spent in the synchronizer, one in entering the pre-release phase, and three in the pre-release clock count. Ticks that arrive before this point are not counted.
- R3: `zero_gate` is high throughout reset and throughout the post-release wait, and it is low only while `data_valid` is high.
- R4: `data_valid` rises on the edge that delivers the `RELEASE_PERIODS`-th sample tick after `conv_rst` has fallen, and not before.
- R5: If any condition becomes false during the post-release wait, the sequence restarts from reset, `data_valid` stays low, and a full new wait of `RELEASE_PERIODS` ticks is needed.
- R6: `pdn` rises on the tick numbered `PDN_PERIODS`+1 that occurs while the synchronized `ext_rst_n` is low, and not on any earlier tick.
- R7: `pdn` falls on the first clock after the synchronized `ext_rst_n` is high, which is the third rising edge after the port rises. The full release wait then runs again.
- R8: In master mode (`is_master`=1) the tick is generated internally every N system clocks, and `lr_tick` has no effect. `ratio_sel` selects N: code 0 gives 128, 1 gives 192, 2 gives 256, 3 gives 384, 4 gives 512, 5 gives 768, and codes 6 and 7 give 256.
- R9: In slave mode (`is_master`=0) each clock cycle in which `lr_tick` is high counts as one sample tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low flop reset |
| ext_rst_n | input | 1 | External reset request, low = reset |
| vlo_ok | input | 1 | Low-voltage supply good |
| vhi_ok | input | 1 | High-voltage supply good |
| is_master | input | 1 | 1 = internal tick divider, 0 = external tick |
| ratio_sel | input | 3 | System-clock-to-sample-rate ratio code |
| lr_tick | input | 1 | One-cycle sample strobe used in slave mode |
| conv_rst | output | 1 | Internal converter reset, active high |
| zero_gate | output | 1 | 1 = force digital output to zero |
| data_valid | output | 1 | Output data valid |
| pdn | output | 1 | Power-down active |

## Verification
The hardest state to reach from the ports is power-down followed by recovery. Reaching it needs a reset request that is held low across more sample periods than the power-down threshold, with the tick counted exactly. The bench therefore scales both thresholds down through parameters and runs in slave mode, where it places each `lr_tick` strobe itself. This lets it check the flag on the exact boundary tick and then confirm that a full release wait follows. Master-mode timing is checked against a window, because the free-running divider phase is unknown. During that test `lr_tick` is held high, so any leak of the external strobe would make the release far too early.

// File: rtl/conv_rst_pkg.sv
package conv_rst_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_PRECLK = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_t;

  localparam int DIV_W = 10;

  // terminal count of the master-mode divider (ratio - 1)
  function automatic logic [DIV_W-1:0] ratio_limit(input logic [2:0] code);
    logic [DIV_W-1:0] lim;
    case (code)
      3'd0:    lim = DIV_W'(127);
      3'd1:    lim = DIV_W'(191);
      3'd2:    lim = DIV_W'(255);
      3'd3:    lim = DIV_W'(383);
      3'd4:    lim = DIV_W'(511);
      3'd5:    lim = DIV_W'(767);
      default: lim = DIV_W'(255);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          pipe[g] <= '0;
        end else if (g == 0) begin
          pipe[g] <= d;
        end else begin
          pipe[g] <= pipe[(g > 0) ? g-1 : 0];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/tick_gen.sv
module tick_gen
  import conv_rst_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       is_master,
  input  logic [2:0] ratio_sel,
  input  logic       lr_tick,
  output logic       tick
);

  logic [DIV_W-1:0] div_cnt, div_cnt_n, div_lim;
  logic             div_hit;

  assign div_lim = ratio_limit(ratio_sel);
  assign div_hit = (div_cnt >= div_lim);

  always_comb begin
    div_cnt_n = div_cnt;
    if (!is_master)   div_cnt_n = '0;
    else if (div_hit) div_cnt_n = '0;
    else              div_cnt_n = div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) div_cnt <= '0;
    else         div_cnt <= div_cnt_n;
  end

  assign tick = is_master ? div_hit : lr_tick;

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import conv_rst_pkg::*;
#(
  parameter int PRE_CLKS        = 3,
  parameter int RELEASE_PERIODS = 1116,
  parameter int PDN_PERIODS     = 65536
) (
  input  logic clk,
  input  logic arst_n,
  input  logic ext_ok,
  input  logic sup_ok,
  input  logic tick,
  output logic conv_rst,
  output logic zero_gate,
  output logic data_valid,
  output logic pdn
);

  localparam int PRE_W = $clog2(PRE_CLKS + 1);
  localparam int REL_W = $clog2(RELEASE_PERIODS + 1);
  localparam int CNT_W = (PRE_W > REL_W) ? PRE_W : REL_W;
  localparam int PDN_W = $clog2(PDN_PERIODS + 2);

  seq_state_t       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [PDN_W-1:0] pd_cnt, pd_cnt_n;
  logic             pdn_q, pdn_n;
  logic             all_ok;

  assign all_ok = ext_ok & sup_ok;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      ST_HOLD: begin
        st_n  = ST_PRECLK;
        cnt_n = '0;
      end
      ST_PRECLK: begin
        if (cnt == CNT_W'(PRE_CLKS - 1)) begin
          st_n  = ST_WAIT;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_WAIT: begin
        if (tick) begin
          if (cnt == CNT_W'(RELEASE_PERIODS - 1)) st_n = ST_RUN;
          else                                    cnt_n = cnt + 1'b1;
        end
      end
      default: st_n = ST_RUN;
    endcase
    if (!all_ok) begin
      st_n  = ST_HOLD;
      cnt_n = '0;
    end
  end

  always_comb begin
    pd_cnt_n = pd_cnt;
    pdn_n    = pdn_q;
    if (ext_ok) begin
      pd_cnt_n = '0;
      pdn_n    = 1'b0;
    end else if (tick && !pdn_q) begin
      if (pd_cnt == PDN_W'(PDN_PERIODS)) pdn_n    = 1'b1;
      else                               pd_cnt_n = pd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st     <= ST_HOLD;
      cnt    <= '0;
      pd_cnt <= '0;
      pdn_q  <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      pd_cnt <= pd_cnt_n;
      pdn_q  <= pdn_n;
    end
  end

  assign conv_rst   = (st == ST_HOLD) || (st == ST_PRECLK);
  assign zero_gate  = (st != ST_RUN);
  assign data_valid = (st == ST_RUN);
  assign pdn        = pdn_q;

endmodule

// File: rtl/conv_rst_seq.sv
module conv_rst_seq #(
  parameter int PRE_CLKS        = 3,
  parameter int RELEASE_PERIODS = 1116,
  parameter int PDN_PERIODS     = 65536,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       ext_rst_n,
  input  logic       vlo_ok,
  input  logic       vhi_ok,
  input  logic       is_master,
  input  logic [2:0] ratio_sel,
  input  logic       lr_tick,
  output logic       conv_rst,
  output logic       zero_gate,
  output logic       data_valid,
  output logic       pdn
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, synced;
  logic             tick;

  assign raw_in = {ext_rst_n, vlo_ok, vhi_ok};

  sync_bank #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (raw_in),
    .q      (synced)
  );

  tick_gen u_tick (
    .clk       (clk),
    .arst_n    (arst_n),
    .is_master (is_master),
    .ratio_sel (ratio_sel),
    .lr_tick   (lr_tick),
    .tick      (tick)
  );

  seq_fsm #(
    .PRE_CLKS        (PRE_CLKS),
    .RELEASE_PERIODS (RELEASE_PERIODS),
    .PDN_PERIODS     (PDN_PERIODS)
  ) u_fsm (
    .clk        (clk),
    .arst_n     (arst_n),
    .ext_ok     (synced[2]),
    .sup_ok     (synced[1] & synced[0]),
    .tick       (tick),
    .conv_rst   (conv_rst),
    .zero_gate  (zero_gate),
    .data_valid (data_valid),
    .pdn        (pdn)
  );

endmodule

// File: rtl/conv_rst_seq_chk.sv
module conv_rst_seq_chk (
  input logic clk,
  input logic arst_n,
  input logic ext_rst_n,
  input logic vlo_ok,
  input logic vhi_ok,
  input logic is_master,
  input logic lr_tick,
  input logic conv_rst,
  input logic zero_gate,
  input logic data_valid,
  input logic pdn
);

  // R1
  rst_follows_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!ext_rst_n || !vlo_ok || !vhi_ok) |-> ##3 conv_rst);

  // R3
  gate_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    conv_rst |-> (zero_gate && !data_valid));

  // R3
  gate_open_only_valid_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !zero_gate |-> data_valid);

  // R4
  valid_after_tick_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(data_valid) |-> ($past(lr_tick) || $past(is_master)));

  // R6
  pdn_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pdn |-> conv_rst);

  // R7
  pdn_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ext_rst_n |-> ##3 !pdn);

endmodule

bind conv_rst_seq conv_rst_seq_chk u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .ext_rst_n  (ext_rst_n),
  .vlo_ok     (vlo_ok),
  .vhi_ok     (vhi_ok),
  .is_master  (is_master),
  .lr_tick    (lr_tick),
  .conv_rst   (conv_rst),
  .zero_gate  (zero_gate),
  .data_valid (data_valid),
  .pdn        (pdn)
);

// File: tb/tb_conv_rst_seq.sv
module tb_conv_rst_seq;

  localparam int REL = 20;
  localparam int PDN = 64;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       ext_rst_n, vlo_ok, vhi_ok, is_master, lr_tick;
  logic [2:0] ratio_sel;
  logic       conv_rst, zero_gate, data_valid, pdn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  conv_rst_seq #(.PRE_CLKS(3), .RELEASE_PERIODS(REL), .PDN_PERIODS(PDN), .SYNC_STAGES(2)) dut (
    .clk(clk), .arst_n(arst_n), .ext_rst_n(ext_rst_n), .vlo_ok(vlo_ok), .vhi_ok(vhi_ok),
    .is_master(is_master), .ratio_sel(ratio_sel), .lr_tick(lr_tick),
    .conv_rst(conv_rst), .zero_gate(zero_gate), .data_valid(data_valid), .pdn(pdn)
  );

  // {ext_rst_n, vlo_ok, vhi_ok, expected conv_rst}
  localparam logic [3:0] VEC [8] = '{
    4'b000_1, 4'b001_1, 4'b010_1, 4'b011_1,
    4'b100_1, 4'b101_1, 4'b110_1, 4'b111_0
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      lr_tick = 1'b1;
      @(negedge clk);
      lr_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    int n;
    int lo;
    int hi;
    arst_n = 1'b0; ext_rst_n = 1'b0; vlo_ok = 1'b0; vhi_ok = 1'b0;
    is_master = 1'b0; ratio_sel = 3'd0; lr_tick = 1'b0;
    cyc(3);
    chk("R1 reset conv_rst", conv_rst, 1'b1);
    chk("R3 reset zero_gate", zero_gate, 1'b1);
    chk("R4 reset data_valid", data_valid, 1'b0);
    chk("R6 reset pdn", pdn, 1'b0);
    arst_n = 1'b1;
    cyc(2);

    // R1 vector walk
    for (int v = 0; v < 8; v++) begin
      {ext_rst_n, vlo_ok, vhi_ok} = VEC[v][3:1];
      cyc(8);
      chk("R1 vector conv_rst", conv_rst, VEC[v][0]);
      chk("R3 vector zero_gate", zero_gate, 1'b1);
    end

    // R2 exact release timing, ticks early ignored
    ext_rst_n = 1'b0;
    cyc(4);
    ext_rst_n = 1'b1;
    lr_tick = 1'b1;
    cyc(5);
    chk("R2 still in reset at edge 5", conv_rst, 1'b1);
    lr_tick = 1'b0;
    cyc(1);
    chk("R2 released at edge 6", conv_rst, 1'b0);
    chk("R3 gate during wait", zero_gate, 1'b1);
    // R4 and R9: slave ticks counted
    pulse(REL - 1);
    chk("R4 not valid before last tick", data_valid, 1'b0);
    chk("R3 gate before last tick", zero_gate, 1'b1);
    pulse(1);
    chk("R4 valid after last tick", data_valid, 1'b1);
    chk("R9 slave tick gate open", zero_gate, 1'b0);

    // R5 restart on supply dip during wait
    ext_rst_n = 1'b0; cyc(4); ext_rst_n = 1'b1; cyc(8);
    pulse(10);
    vhi_ok = 1'b0; cyc(4);
    chk("R5 reset during dip", conv_rst, 1'b1);
    vhi_ok = 1'b1; cyc(8);
    pulse(REL - 1);
    chk("R5 full wait needed again", data_valid, 1'b0);
    pulse(1);
    chk("R5 valid after full wait", data_valid, 1'b1);

    // R6 power-down boundary
    ext_rst_n = 1'b0;
    cyc(4);
    pulse(PDN);
    chk("R6 no pdn at threshold", pdn, 1'b0);
    pulse(1);
    chk("R6 pdn after threshold", pdn, 1'b1);
    chk("R1 reset in pdn", conv_rst, 1'b1);

    // R7 exit
    ext_rst_n = 1'b1;
    cyc(2);
    chk("R7 pdn held through sync", pdn, 1'b1);
    cyc(1);
    chk("R7 pdn cleared", pdn, 1'b0);
    cyc(6);
    pulse(REL - 1);
    chk("R7 full wait after pdn", data_valid, 1'b0);
    pulse(1);
    chk("R7 valid after pdn exit", data_valid, 1'b1);

    // R8 master mode, lr_tick held high must not count
    for (int k = 0; k < 2; k++) begin
      int r;
      ext_rst_n = 1'b0;
      is_master = 1'b1;
      ratio_sel = (k == 0) ? 3'd0 : 3'd5;
      r = (k == 0) ? 128 : 768;
      lr_tick = 1'b1;
      cyc(4);
      ext_rst_n = 1'b1;
      n = 0;
      lo = (REL - 1) * r + 6;
      hi = REL * r + 8;
      while (!data_valid && n <= hi) begin
        cyc(1);
        n++;
      end
      chk("R8 master valid not early", (n >= lo) ? 1'b1 : 1'b0, 1'b1);
      chk("R8 master valid not late", (n <= hi) ? 1'b1 : 1'b0, 1'b1);
    end
    lr_tick = 1'b0;

    done = 1'b1;
    report();
  end

endmodule